// File: doc/BRIEF.md
# Watchdog Supervisor with Reset Control

This block watches a periodic "kick" line from a processor and raises an alarm when the kicks stop. Any change of level on the kick input, rising or falling, restarts the timeout counter. If the programmed number of clock cycles passes with no change, the block drives a short active-low alarm pulse. When the reset enable is set, that pulse is followed by a system reset held for a fixed number of cycles. A sticky cause flag records that the watchdog produced the reset. The flag stays set until the host clears it or power-on reset occurs.

Monitoring begins only after the power-good/boot-done input is high. It can start at once, or after a startup delay chosen by a 3-bit code. Two coupling modes are supported. In the coupled mode, a reset request from the system sequencer parks the watchdog, and the startup delay runs again when that request ends. In the standalone mode the watchdog ignores the sequencer request completely, and the request only reaches the reset output. All pins are plain level controls and status: there is no data stream and no handshake.

Top module: `wdt_supervisor`

## Requirements
- R1: After power-on reset (`por_n` low), `wdo_n` and `rst_n` are high (with `seq_rst` low) and `wdr_flag` is 0.
- R2: Monitoring starts on the first clock edge that sees `pwr_ok` high (and no parking request). With `cfg_start_code` = 0 there is no added delay. A nonzero code c adds `START_UNIT << (c-1)` cycles before the timeout count begins.
- R3: The timeout length is `TMO_BASE << cfg_tmo_sel` clock cycles, counted from the start of monitoring or from the last restart of the count.
- R4: Every level change on `wdi`, rising or falling, restarts the timeout count. A change applied between edges k and k+1 makes the alarm fall after edge k+3+T if no further change comes (two synchronizer stages plus one edge-detect stage).
- R5: On a timeout, `wdo_n` goes low for exactly `WDO_PULSE` cycles.
- R6: With `cfg_rst_en` = 1, `rst_n` falls one cycle after `wdo_n` falls and stays low for `RST_HOLD` cycles. The order is always: alarm falls, reset falls, alarm rises.
- R7: With `cfg_rst_en` = 0, a timeout never lowers `rst_n`. Monitoring resumes as the alarm pulse ends, so the next alarm falls `WDO_PULSE + T` cycles after the previous one.
- R8: After a watchdog reset, the timeout count restarts on the edge after `rst_n` is released. The next alarm therefore falls `RST_HOLD + 2 + T` cycles after the previous one.
- R9: `wdr_flag` is set in the same cycle that the watchdog lowers `rst_n`. It stays set until `wdr_clr` is sampled high, and then reads 0 one cycle later. A sequencer reset never sets it.
- R10: With `cfg_indep` = 1, `seq_rst` drives `rst_n` low in the same cycle but does not change the timeout count or `wdo_n`.
- R11: With `cfg_indep` = 0, `seq_rst` high parks the watchdog (no alarm while it is high). After release, the startup delay and timeout run again from the first edge that sees `seq_rst` low.
- R12: While `pwr_ok` is low the watchdog stays idle, with `wdo_n` high. Dropping `pwr_ok` mid-count abandons the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pwr_ok | input | 1 | Supply good and boot finished |
| seq_rst | input | 1 | Reset request from the system sequencer, active high |
| wdi | input | 1 | Kick input, asynchronous |
| cfg_rst_en | input | 1 | 1: a timeout also asserts the system reset |
| cfg_indep | input | 1 | 1: standalone mode, immune to `seq_rst` |
| cfg_start_code | input | 3 | Startup delay code, 0 = none |
| cfg_tmo_sel | input | SEL_W | Timeout length select |
| wdr_clr | input | 1 | Clears the sticky cause flag |
| wdo_n | output | 1 | Watchdog alarm, active low |
| rst_n | output | 1 | System reset, active low |
| wdr_flag | output | 1 | Sticky: last reset came from the watchdog |

## Verification
Every result has a fixed latency, and the bench counts falling clock edges from the cycle in which it drives a stimulus. A `pwr_ok` or `seq_rst` release is expected to lower the alarm D+T+1 samples later. A kick change lowers it 3+T samples later. Once the alarm falls, the bench expects the reset to fall at the next sample, the alarm to rise P samples on, the reset to rise 1+R samples on, and the next alarm at R+2+T (with reset) or P+T (without). All inputs change on the falling edge and outputs are read only there, so each expected index is exact and has no tolerance window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [2:0] {
    WS_IDLE  = 3'd0,
    WS_DELAY = 3'd1,
    WS_WATCH = 3'd2,
    WS_ALARM = 3'd3,
    WS_HOLD  = 3'd4
  } wdt_state_e;

  // timeout length in cycles for a select value
  function automatic int unsigned tmo_cycles(input int unsigned base, input int unsigned sel);
    return base << sel;
  endfunction

  // startup delay in cycles for a nonzero code; code 0 means none
  function automatic int unsigned start_cycles(input int unsigned unit, input int unsigned code);
    return (code == 0) ? 0 : (unit << (code - 1));
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic kick_async,
  output logic kick_edge
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] chain;
  logic          last_q;

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[0] <= 1'b0;
          else        chain[0] <= kick_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) last_q <= 1'b0;
    else        last_q <= chain[NS-1];
  end

  // either polarity counts as a kick
  assign kick_edge = chain[NS-1] ^ last_q;

endmodule

// File: rtl/wdt_core_fsm.sv
module wdt_core_fsm
  import wdt_pkg::*;
#(
  parameter int TMO_BASE   = 16,
  parameter int SEL_W      = 2,
  parameter int START_UNIT = 8,
  parameter int WDO_PULSE  = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pwr_ok,
  input  logic             seq_rst,
  input  logic             kick_edge,
  input  logic             cfg_rst_en,
  input  logic             cfg_indep,
  input  logic [2:0]       cfg_start_code,
  input  logic [SEL_W-1:0] cfg_tmo_sel,
  input  logic             wd_rst,
  output logic             alarm,
  output logic             rst_req
);
  localparam int unsigned PULSE_CYC = (WDO_PULSE < 2) ? 2 : WDO_PULSE;
  localparam int unsigned TMO_MAX   = tmo_cycles(TMO_BASE, (1 << SEL_W) - 1);
  localparam int unsigned DLY_MAX   = start_cycles(START_UNIT, 7);
  localparam int unsigned CNT_MAX   = max2(max2(TMO_MAX, DLY_MAX), PULSE_CYC);
  localparam int          CNT_W     = $clog2(CNT_MAX + 1);

  wdt_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tmo_last;
  logic [CNT_W-1:0] dly_last;
  logic             rst_en_q;
  logic             parked;

  always_comb begin
    tmo_last = CNT_W'(tmo_cycles(TMO_BASE, 32'(cfg_tmo_sel)) - 1);
    dly_last = CNT_W'(start_cycles(START_UNIT, 32'(cfg_start_code)) - 1);
  end

  // coupled mode: a sequencer request holds the watchdog idle
  assign parked = !pwr_ok || (!cfg_indep && seq_rst);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= WS_IDLE;
      cnt      <= '0;
      rst_en_q <= 1'b0;
    end else if (parked) begin
      st       <= WS_IDLE;
      cnt      <= '0;
      rst_en_q <= 1'b0;
    end else begin
      case (st)
        WS_IDLE: begin
          cnt <= '0;
          st  <= (cfg_start_code == 3'd0) ? WS_WATCH : WS_DELAY;
        end
        WS_DELAY: begin
          if (cnt == dly_last) begin
            cnt <= '0;
            st  <= WS_WATCH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WS_WATCH: begin
          if (kick_edge) begin
            cnt <= '0;
          end else if (cnt == tmo_last) begin
            cnt      <= '0;
            st       <= WS_ALARM;
            rst_en_q <= cfg_rst_en;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WS_ALARM: begin
          if (cnt == CNT_W'(PULSE_CYC - 1)) begin
            cnt <= '0;
            st  <= rst_en_q ? WS_HOLD : WS_WATCH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        WS_HOLD: begin
          if (!wd_rst) begin
            cnt <= '0;
            st  <= WS_WATCH;
          end
        end
        default: begin
          cnt <= '0;
          st  <= WS_IDLE;
        end
      endcase
    end
  end

  assign alarm   = (st == WS_ALARM);
  assign rst_req = (st == WS_ALARM) && (cnt == '0) && rst_en_q;

  // R3: the running count never passes the selected timeout
  p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!por_n)
    (st == WS_WATCH) |-> (cnt <= tmo_last));

  // R10: in standalone mode a sequencer request does not disturb a running count
  p_indep_ignores_seq_r10: assert property (@(posedge clk) disable iff (!por_n)
    (st == WS_WATCH && cfg_indep && seq_rst && pwr_ok && !kick_edge && cnt != tmo_last)
      |=> (st == WS_WATCH && cnt == $past(cnt) + 1'b1));

  // R11: in coupled mode a sequencer request parks the watchdog
  p_dep_parks_r11: assert property (@(posedge clk) disable iff (!por_n)
    (!cfg_indep && seq_rst) |=> (st == WS_IDLE && !alarm));

  // R12: no supply-good, no monitoring
  p_idle_without_pwr_r12: assert property (@(posedge clk) disable iff (!por_n)
    !pwr_ok |=> (st == WS_IDLE));

endmodule

// File: rtl/wdt_reset_ctrl.sv
module wdt_reset_ctrl #(
  parameter int RST_HOLD = 6
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_req,
  input  logic flag_clr,
  output logic wd_rst,
  output logic wdr_flag
);
  localparam int HOLD_CYC = (RST_HOLD < 1) ? 1 : RST_HOLD;
  localparam int HCNT_W   = $clog2(HOLD_CYC + 1);

  logic [HCNT_W-1:0] hcnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wd_rst <= 1'b0;
      hcnt   <= '0;
    end else if (rst_req) begin
      wd_rst <= 1'b1;
      hcnt   <= '0;
    end else if (wd_rst) begin
      if (hcnt == HCNT_W'(HOLD_CYC - 1)) wd_rst <= 1'b0;
      else                               hcnt   <= hcnt + 1'b1;
    end
  end

  // set wins over clear
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        wdr_flag <= 1'b0;
    else if (rst_req)  wdr_flag <= 1'b1;
    else if (flag_clr) wdr_flag <= 1'b0;
  end

  // R9: the cause flag is raised together with the watchdog reset
  p_flag_with_rst_r9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wd_rst) |-> wdr_flag);

  // R7: the watchdog reset only starts on a request from the core
  p_rst_only_on_req_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wd_rst) |-> $past(rst_req));

  // R9: the flag drops only on a clear
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wdr_flag) |-> $past(flag_clr));

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int SYNC_STAGES = 2,
  parameter int TMO_BASE    = 16,
  parameter int SEL_W       = 2,
  parameter int START_UNIT  = 8,
  parameter int WDO_PULSE   = 4,
  parameter int RST_HOLD    = 6
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pwr_ok,
  input  logic             seq_rst,
  input  logic             wdi,
  input  logic             cfg_rst_en,
  input  logic             cfg_indep,
  input  logic [2:0]       cfg_start_code,
  input  logic [SEL_W-1:0] cfg_tmo_sel,
  input  logic             wdr_clr,
  output logic             wdo_n,
  output logic             rst_n,
  output logic             wdr_flag
);
  logic kick_edge;
  logic alarm;
  logic rst_req;
  logic wd_rst;

  wdt_kick_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .por_n      (por_n),
    .kick_async (wdi),
    .kick_edge  (kick_edge)
  );

  wdt_core_fsm #(
    .TMO_BASE   (TMO_BASE),
    .SEL_W      (SEL_W),
    .START_UNIT (START_UNIT),
    .WDO_PULSE  (WDO_PULSE)
  ) core_i (
    .clk            (clk),
    .por_n          (por_n),
    .pwr_ok         (pwr_ok),
    .seq_rst        (seq_rst),
    .kick_edge      (kick_edge),
    .cfg_rst_en     (cfg_rst_en),
    .cfg_indep      (cfg_indep),
    .cfg_start_code (cfg_start_code),
    .cfg_tmo_sel    (cfg_tmo_sel),
    .wd_rst         (wd_rst),
    .alarm          (alarm),
    .rst_req        (rst_req)
  );

  wdt_reset_ctrl #(.RST_HOLD(RST_HOLD)) rctl_i (
    .clk      (clk),
    .por_n    (por_n),
    .rst_req  (rst_req),
    .flag_clr (wdr_clr),
    .wd_rst   (wd_rst),
    .wdr_flag (wdr_flag)
  );

  assign wdo_n = !alarm;
  assign rst_n = !(wd_rst || seq_rst);

  // R6: the watchdog reset rises only while the alarm is already low
  p_alarm_before_rst_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wd_rst) |-> !wdo_n);

endmodule

// File: tb/wdt_supervisor_tb_top.sv
module wdt_supervisor_tb_top;
  localparam int TB = 16;
  localparam int SU = 8;
  localparam int PW = 4;
  localparam int RH = 6;

  logic       clk = 1'b0;
  logic       por_n, pwr_ok, seq_rst, wdi, rst_en, indep, wdr_clr;
  logic [2:0] code;
  logic [1:0] sel;
  logic       wdo_n, rst_n, wdr_flag;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  wdt_supervisor #(
    .SYNC_STAGES(2), .TMO_BASE(TB), .SEL_W(2),
    .START_UNIT(SU), .WDO_PULSE(PW), .RST_HOLD(RH)
  ) dut_i (
    .clk(clk), .por_n(por_n), .pwr_ok(pwr_ok), .seq_rst(seq_rst), .wdi(wdi),
    .cfg_rst_en(rst_en), .cfg_indep(indep), .cfg_start_code(code),
    .cfg_tmo_sel(sel), .wdr_clr(wdr_clr),
    .wdo_n(wdo_n), .rst_n(rst_n), .wdr_flag(wdr_flag)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  function automatic int tmo(input int s);
    return TB << s;
  endfunction

  function automatic int dly(input int c);
    return (c == 0) ? 0 : (SU << (c - 1));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts falling edges until the alarm is seen low
  task automatic wait_alarm(input int lim, output int n, output int rst_seen);
    n = 0;
    rst_seen = 0;
    do begin
      @(negedge clk);
      n++;
      if (!rst_n) rst_seen = 1;
    end while (wdo_n && n < lim);
  endtask

  // called on the sample where the alarm just fell; records transition indexes
  task automatic observe(input int lim, output int k_rf, output int k_rr,
                         output int k_wr, output int k_wf);
    k_rf = -1; k_rr = -1; k_wr = -1; k_wf = -1;
    for (int k = 0; k <= lim; k++) begin
      if (k > 0) @(negedge clk);
      if (!rst_n && k_rf < 0) k_rf = k;
      if (rst_n && k_rf >= 0 && k_rr < 0) k_rr = k;
      if (wdo_n && k_wr < 0) k_wr = k;
      if (!wdo_n && k_wr >= 0 && k_wf < 0) begin
        k_wf = k;
        break;
      end
    end
  endtask

  // returns to idle, then raises supply-good on the current falling edge
  task automatic restart();
    @(negedge clk); pwr_ok = 1'b0;
    @(negedge clk); pwr_ok = 1'b1;
  endtask

  // low samples of the given signal over n cycles
  task automatic count_low(input int n, output int wlow, output int rlow);
    wlow = 0; rlow = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!wdo_n) wlow++;
      if (!rst_n) rlow++;
    end
  endtask

  initial begin
    int n, rs, rf, rr, wr, wf, wl, rl;
    por_n = 1'b0; pwr_ok = 1'b0; seq_rst = 1'b0; wdi = 1'b0;
    rst_en = 1'b0; indep = 1'b1; wdr_clr = 1'b0; code = 3'd0; sel = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 wdo_n in reset", int'(wdo_n), 1);
    chk("R1 rst_n in reset", int'(rst_n), 1);
    chk("R1 flag in reset", int'(wdr_flag), 0);
    por_n = 1'b1;

    // R12: no supply-good, nothing happens
    count_low(300, wl, rl);
    chk("R12 alarm while pwr_ok low", wl, 0);
    chk("R12 reset while pwr_ok low", rl, 0);
    chk("R1 flag after idle", int'(wdr_flag), 0);

    // R2/R3/R5/R7: sweep startup codes and timeout selects, no reset
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        sel = 2'(s); code = 3'(c); rst_en = 1'b0;
        restart();
        wait_alarm(dly(c) + tmo(s) + 20, n, rs);
        chk($sformatf("R2 R3 start-to-alarm sel=%0d code=%0d", s, c), n, dly(c) + tmo(s) + 1);
        observe(tmo(s) + PW + 10, rf, rr, wr, wf);
        chk($sformatf("R5 alarm width sel=%0d code=%0d", s, c), wr, PW);
        chk($sformatf("R7 no reset sel=%0d code=%0d", s, c), rf, -1);
        chk($sformatf("R7 re-arm sel=%0d code=%0d", s, c), wf, PW + tmo(s));
      end
    end

    // R6/R8/R9: reset enabled, both coupling modes, every timeout select
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        indep = 1'(m); sel = 2'(s); code = 3'd0; rst_en = 1'b1;
        restart();
        wait_alarm(tmo(s) + 20, n, rs);
        chk($sformatf("R3 timeout indep=%0d sel=%0d", m, s), n, tmo(s) + 1);
        chk("R6 reset not before alarm", int'(rst_n), 1);
        observe(RH + tmo(s) + 10, rf, rr, wr, wf);
        chk($sformatf("R6 reset fall index sel=%0d", s), rf, 1);
        chk($sformatf("R6 reset width sel=%0d", s), rr - rf, RH);
        chk($sformatf("R6 alarm rises inside reset sel=%0d", s), int'(wr > rf && wr < rr), 1);
        chk($sformatf("R8 re-arm after reset sel=%0d", s), wf, RH + 2 + tmo(s));
        chk("R9 flag sticky", int'(wdr_flag), 1);
        rst_en = 1'b0;
        repeat (RH + PW + 4) @(negedge clk);
        chk("R9 flag still set", int'(wdr_flag), 1);
        wdr_clr = 1'b1;
        @(negedge clk); wdr_clr = 1'b0;
        chk("R9 flag cleared", int'(wdr_flag), 0);
      end
    end

    // R4: kicks of both polarities keep the alarm away
    indep = 1'b1; rst_en = 1'b0; code = 3'd0; sel = 2'd1;
    restart();
    wl = 0;
    for (int i = 0; i < 20; i++) begin
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (!wdo_n) wl++;
      end
      wdi = ~wdi;
    end
    chk("R4 no alarm under regular kicks", wl, 0);
    wait_alarm(tmo(1) + 20, n, rs);
    chk("R4 alarm after last falling kick", n, 3 + tmo(1));
    restart();
    repeat (10) @(negedge clk);
    wdi = 1'b1;
    wait_alarm(tmo(1) + 20, n, rs);
    chk("R4 alarm after rising kick", n, 3 + tmo(1));
    restart();
    repeat (10) @(negedge clk);
    wdi = 1'b0;
    wait_alarm(tmo(1) + 20, n, rs);
    chk("R4 alarm after falling kick", n, 3 + tmo(1));

    // R10: standalone mode ignores a sequencer request
    indep = 1'b1; sel = 2'd0; code = 3'd0; rst_en = 1'b0;
    restart();
    n = 0;
    rl = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 5) seq_rst = 1'b1;
      if (n == 6) rl = int'(rst_n);
    end while (wdo_n && n < 100);
    chk("R10 seq_rst reaches rst_n", rl, 0);
    chk("R10 timeout unchanged by seq_rst", n, tmo(0) + 1);
    seq_rst = 1'b0;
    chk("R9 seq reset leaves flag clear", int'(wdr_flag), 0);

    // R11: coupled mode parks on a sequencer request
    for (int c = 0; c < 3; c++) begin
      indep = 1'b0; sel = 2'd0; code = 3'(c);
      restart();
      repeat (3) @(negedge clk);
      seq_rst = 1'b1;
      count_low(dly(c) + tmo(0) + 20, wl, rl);
      chk($sformatf("R11 no alarm while parked code=%0d", c), wl, 0);
      seq_rst = 1'b0;
      wait_alarm(dly(c) + tmo(0) + 20, n, rs);
      chk($sformatf("R11 restart after release code=%0d", c), n, dly(c) + tmo(0) + 1);
    end
    chk("R9 flag clear after coupled tests", int'(wdr_flag), 0);

    // R12: losing supply-good mid-count abandons it
    indep = 1'b1; code = 3'd0; sel = 2'd0;
    restart();
    repeat (10) @(negedge clk);
    pwr_ok = 1'b0;
    count_low(200, wl, rl);
    chk("R12 alarm after pwr_ok drop", wl, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule